// File: doc/BRIEF.md
# Four-Bank Asynchronous Static Memory Sequencer

This block turns single host read and write requests into asynchronous bus cycles for SRAM, ROM and NOR-style parts on up to four external banks. Each bank has its own active-low chip select. The address lines, data lines, output enable, write enable and address-valid strobe are shared by all banks. Bits [27:26] of the host byte address pick the bank, so each bank covers a fixed 64 MB window.

Every bank has its own static configuration, applied on plain input pins. The configuration enables the bank, chooses a plain or a multiplexed address/data bus, and sets the data width to 8, 16 or 32 bits. It also sets three phase lengths in controller clocks: address setup, address hold and data. On a multiplexed bank, the memory address is placed on the data lines during address setup and kept there through an address-hold phase. While that address is valid, the address-valid strobe is low.

The host side is a request channel and a response channel, each with valid/ready. A request is accepted only in a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low while a bus cycle is running and while a response is still waiting. The host therefore applies back-pressure simply by holding `rsp_ready` low, and no second request is taken until the response has been consumed. A response stays valid, with its data and error flag unchanged, until it is accepted.

Top module: `xbus_ctrl`

## Requirements
- R1: Host address bits [27:26] select bank b. During a transaction, `mem_ne[b]` is low from the first address-setup cycle to the last data cycle. The other three chip selects stay high, and at most one chip select is ever low.
- R2: The address-setup phase lasts C+1 clocks, where C is the bank's 4-bit field `cfg_ast[4b+3:4b]`. This gives 1 to 16 clocks.
- R3: When `cfg_mux[b]`=1, `mem_nadv` is low for the whole address-setup phase. An address-hold phase of max(C,1)+1 clocks follows, where C is `cfg_aht[4b+3:4b]`, giving 2 to 16 clocks. During hold, `mem_nadv` is high. The memory address, zero-extended, is driven on `mem_dout` with `mem_doe`=1 through both phases. When `cfg_mux[b]`=0 there is no hold phase, `mem_nadv` stays high, and `mem_doe` is low during address setup.
- R4: The data phase lasts max(C,1)+1 clocks, where C is the bank's 8-bit field `cfg_dst[8b+7:8b]`. This gives 2 to 256 clocks.
- R5: On a read, `mem_noe` is low for the whole data phase and `mem_nwe` stays high. The returned `rsp_rdata` is the value on `mem_din` in the last data clock, masked to the bank width.
- R6: On a write, `mem_nwe` is low for every data clock except the last, and `mem_noe` stays high. `mem_doe`=1 for the whole data phase, and `mem_dout` carries the masked write data, unchanged while `mem_nwe` is low. `mem_nwe` rises while the chip select is still low.
- R7: The 2-bit `cfg_wid[2b+1:2b]` sets the width: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. `mem_addr` is the byte address bits [25:0] shifted right by 0, 1 or 2 places to match. Read data is zero-extended above the width, and write data is zeroed above it.
- R8: After the data phase there is one clock in which all chip selects, `mem_noe`, `mem_nwe` and `mem_nadv` are high. `rsp_valid` rises in that clock with `rsp_err`=0. Two transactions never share a chip-select low period.
- R9: A request to a bank with `cfg_en[b]`=0 drives no strobe. It gives `rsp_valid`=1, `rsp_err`=1 and `rsp_rdata`=0 in the clock after acceptance.
- R10: `req_ready` is high only when no transaction is running and no response is pending. While `rsp_valid` is high and `rsp_ready` is low, the response and its data and error flag hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 4 | Per-bank enable |
| cfg_mux | input | 4 | Per-bank multiplexed address/data select |
| cfg_wid | input | 8 | Per-bank width code, 2 bits each |
| cfg_ast | input | 16 | Per-bank address-setup code, 4 bits each |
| cfg_aht | input | 16 | Per-bank address-hold code, 4 bits each |
| cfg_dst | input | 32 | Per-bank data-phase code, 8 bits each |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Host byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host accepts response |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access hit a disabled bank |
| mem_ne | output | 4 | Active-low chip selects, one per bank |
| mem_nadv | output | 1 | Active-low address-valid strobe |
| mem_noe | output | 1 | Active-low output enable |
| mem_nwe | output | 1 | Active-low write enable |
| mem_addr | output | 26 | Memory word address |
| mem_dout | output | 32 | Data/address driven toward memory |
| mem_doe | output | 1 | Drive enable for mem_dout |
| mem_din | input | 32 | Data from memory |

## Verification
The bench runs reads and writes across all four banks, and each bank uses a different mix of bus mode, width and phase codes. Setup codes 0 and 15, hold code 0 (raised to two clocks) and the largest data code separate the phase-length rules from one another. Between them they also separate the mux-only hold phase and address-valid strobe from the plain bus. `mem_din` changes every clock, so the read value shows that the sample is taken in the last data clock and not earlier. A disabled-bank access shows the error path. Responses held back for several clocks show that the response stays stable and that no new request is taken before it is consumed.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

  localparam int CYC_W = 9;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ASET,
    PH_AHLD,
    PH_DATA,
    PH_GAP
  } phase_e;

  typedef enum logic [1:0] {
    WID_8   = 2'd0,
    WID_16  = 2'd1,
    WID_32  = 2'd2,
    WID_32B = 2'd3
  } width_e;

  typedef struct packed {
    logic             en;
    logic             mux;
    logic [1:0]       wid;
    logic [CYC_W-1:0] ast;
    logic [CYC_W-1:0] aht;
    logic [CYC_W-1:0] dst;
  } bank_tim_t;

  function automatic logic [CYC_W-1:0] floor_two(input logic [CYC_W-1:0] code);
    return (code == '0) ? CYC_W'(2) : code + CYC_W'(1);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] wid);
    case (wid)
      WID_8:   return 32'h0000_00FF;
      WID_16:  return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/xbus_bank_sel.sv
`timescale 1ns/1ps
module xbus_bank_sel
  import xbus_pkg::*;
#(
  parameter int NB     = 4,
  parameter int AST_W  = 4,
  parameter int AHT_W  = 4,
  parameter int DST_W  = 8,
  localparam int BSEL_W = $clog2(NB)
) (
  input  logic [NB-1:0]       cfg_en,
  input  logic [NB-1:0]       cfg_mux,
  input  logic [2*NB-1:0]     cfg_wid,
  input  logic [AST_W*NB-1:0] cfg_ast,
  input  logic [AHT_W*NB-1:0] cfg_aht,
  input  logic [DST_W*NB-1:0] cfg_dst,
  input  logic [BSEL_W-1:0]   bank_i,
  output bank_tim_t           tim_o
);

  bank_tim_t tim [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign tim[b] = '{
      en:  cfg_en[b],
      mux: cfg_mux[b],
      wid: cfg_wid[2*b +: 2],
      ast: CYC_W'(cfg_ast[AST_W*b +: AST_W]) + CYC_W'(1),
      aht: floor_two(CYC_W'(cfg_aht[AHT_W*b +: AHT_W])),
      dst: floor_two(CYC_W'(cfg_dst[DST_W*b +: DST_W]))
    };
  end

  assign tim_o = tim[bank_i];

endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int NB = 4,
  parameter int AW = 28,
  parameter int DW = 32,
  localparam int BSEL_W = $clog2(NB),
  localparam int BA_W   = AW - BSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  bank_tim_t         tim_i,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  input  logic [DW-1:0]     mem_din,
  output phase_e            phase_o,
  output logic [CYC_W-1:0]  cnt_o,
  output logic [BSEL_W-1:0] bank_o,
  output logic              write_o,
  output logic [BA_W-1:0]   addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              mux_o,
  output logic [1:0]        wid_o
);

  phase_e            phase_q;
  logic [CYC_W-1:0]  cnt_q, aht_q, dst_q;
  logic [BSEL_W-1:0] bank_q;
  logic              write_q, mux_q;
  logic [BA_W-1:0]   addr_q;
  logic [DW-1:0]     wdata_q;
  logic [1:0]        wid_q;
  logic              rsp_valid_q, rsp_err_q;
  logic [DW-1:0]     rsp_rdata_q;
  logic              take;

  assign req_ready = (phase_q == PH_IDLE) && !rsp_valid_q;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      aht_q       <= '0;
      dst_q       <= '0;
      bank_q      <= '0;
      write_q     <= 1'b0;
      mux_q       <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      wid_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      if (rsp_valid_q && rsp_ready) rsp_valid_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (take) begin
            bank_q  <= req_addr[AW-1 -: BSEL_W];
            addr_q  <= req_addr[BA_W-1:0];
            write_q <= req_write;
            wdata_q <= req_wdata;
            mux_q   <= tim_i.mux;
            wid_q   <= tim_i.wid;
            aht_q   <= tim_i.aht;
            dst_q   <= tim_i.dst;
            if (!tim_i.en) begin
              rsp_valid_q <= 1'b1;
              rsp_err_q   <= 1'b1;
              rsp_rdata_q <= '0;
            end else begin
              phase_q <= PH_ASET;
              cnt_q   <= tim_i.ast - CYC_W'(1);
            end
          end
        end
        PH_ASET: begin
          if (cnt_q == '0) begin
            if (mux_q) begin
              phase_q <= PH_AHLD;
              cnt_q   <= aht_q - CYC_W'(1);
            end else begin
              phase_q <= PH_DATA;
              cnt_q   <= dst_q - CYC_W'(1);
            end
          end else begin
            cnt_q <= cnt_q - CYC_W'(1);
          end
        end
        PH_AHLD: begin
          if (cnt_q == '0) begin
            phase_q <= PH_DATA;
            cnt_q   <= dst_q - CYC_W'(1);
          end else begin
            cnt_q <= cnt_q - CYC_W'(1);
          end
        end
        PH_DATA: begin
          if (cnt_q == '0) begin
            phase_q     <= PH_GAP;
            rsp_valid_q <= 1'b1;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= write_q ? '0 : (mem_din & DW'(lane_mask(wid_q)));
          end else begin
            cnt_q <= cnt_q - CYC_W'(1);
          end
        end
        PH_GAP:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
  assign phase_o   = phase_q;
  assign cnt_o     = cnt_q;
  assign bank_o    = bank_q;
  assign write_o   = write_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign mux_o     = mux_q;
  assign wid_o     = wid_q;

  // R10: a pending response is frozen until the host takes it
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_ready) |=> (rsp_valid_q && $stable(rsp_rdata_q) && $stable(rsp_err_q)));

  // R10: no request is taken while a response waits
  assert_no_take_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |-> !take);

  // R4: the data counter never exceeds the latched phase length
  assert_data_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA) |-> (cnt_q < dst_q));

  // R8: a response is raised only from the data phase or an error accept
  assert_rsp_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid_q) |-> ((phase_q == PH_GAP) || (phase_q == PH_IDLE && rsp_err_q)));

endmodule

// File: rtl/xbus_pins.sv
`timescale 1ns/1ps
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int NB   = 4,
  parameter int AW   = 28,
  parameter int DW   = 32,
  localparam int BSEL_W = $clog2(NB),
  localparam int BA_W   = AW - BSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  logic [CYC_W-1:0]  cnt_i,
  input  logic [BSEL_W-1:0] bank_i,
  input  logic              write_i,
  input  logic [BA_W-1:0]   addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              mux_i,
  input  logic [1:0]        wid_i,
  output logic [NB-1:0]     mem_ne,
  output logic              mem_nadv,
  output logic              mem_noe,
  output logic              mem_nwe,
  output logic [BA_W-1:0]   mem_addr,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_doe
);

  logic addr_ph, data_ph, active;

  assign addr_ph = (phase_i == PH_ASET) || (phase_i == PH_AHLD);
  assign data_ph = (phase_i == PH_DATA);
  assign active  = addr_ph || data_ph;

  for (genvar b = 0; b < NB; b++) begin : g_cs
    assign mem_ne[b] = !(active && (bank_i == BSEL_W'(b)));
  end

  always_comb begin
    case (wid_i)
      WID_8:   mem_addr = addr_i;
      WID_16:  mem_addr = addr_i >> 1;
      default: mem_addr = addr_i >> 2;
    endcase
  end

  assign mem_nadv = !((phase_i == PH_ASET) && mux_i);
  assign mem_noe  = !(data_ph && !write_i);
  assign mem_nwe  = !(data_ph && write_i && (cnt_i != '0));
  assign mem_doe  = (addr_ph && mux_i) || (data_ph && write_i);
  assign mem_dout = addr_ph ? DW'(mem_addr) : (wdata_i & DW'(lane_mask(wid_i)));

  // R1: never more than one bank selected
  assert_one_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_ne) <= 1);

  // R8: chip select cannot hop from one bank to another without an idle clock
  assert_no_bank_hop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&mem_ne) && !$past(&mem_ne)) |-> $stable(mem_ne));

  // R5/R6: read and write enables are exclusive and only inside a selection
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_noe && !mem_nwe));
  assert_strobe_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_noe || !mem_nwe) |-> !(&mem_ne));

  // R3: address-valid strobe only while the address is on the data lines
  assert_adv_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_nadv |-> (mem_doe && !(&mem_ne)));

  // R6: write data steady while write enable is low
  assert_wdata_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_nwe && $past(!mem_nwe)) |-> $stable(mem_dout));

  // R6: write enable rises before the chip select is released
  assert_nwe_rise_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_nwe) |-> (!(&mem_ne) && mem_doe));

endmodule

// File: rtl/xbus_ctrl.sv
`timescale 1ns/1ps
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int NB    = 4,
  parameter int AW    = 28,
  parameter int DW    = 32,
  parameter int AST_W = 4,
  parameter int AHT_W = 4,
  parameter int DST_W = 8,
  localparam int BSEL_W = $clog2(NB),
  localparam int BA_W   = AW - BSEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NB-1:0]       cfg_en,
  input  logic [NB-1:0]       cfg_mux,
  input  logic [2*NB-1:0]     cfg_wid,
  input  logic [AST_W*NB-1:0] cfg_ast,
  input  logic [AHT_W*NB-1:0] cfg_aht,
  input  logic [DST_W*NB-1:0] cfg_dst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DW-1:0]       rsp_rdata,
  output logic                rsp_err,
  output logic [NB-1:0]       mem_ne,
  output logic                mem_nadv,
  output logic                mem_noe,
  output logic                mem_nwe,
  output logic [BA_W-1:0]     mem_addr,
  output logic [DW-1:0]       mem_dout,
  output logic                mem_doe,
  input  logic [DW-1:0]       mem_din
);

  bank_tim_t         tim;
  phase_e            phase;
  logic [CYC_W-1:0]  cnt;
  logic [BSEL_W-1:0] bank;
  logic              wr, mux;
  logic [BA_W-1:0]   baddr;
  logic [DW-1:0]     wdata;
  logic [1:0]        wid;

  xbus_bank_sel #(.NB(NB), .AST_W(AST_W), .AHT_W(AHT_W), .DST_W(DST_W)) u_sel (
    .cfg_en (cfg_en),
    .cfg_mux(cfg_mux),
    .cfg_wid(cfg_wid),
    .cfg_ast(cfg_ast),
    .cfg_aht(cfg_aht),
    .cfg_dst(cfg_dst),
    .bank_i (req_addr[AW-1 -: BSEL_W]),
    .tim_o  (tim)
  );

  xbus_seq #(.NB(NB), .AW(AW), .DW(DW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .tim_i    (tim),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err),
    .mem_din  (mem_din),
    .phase_o  (phase),
    .cnt_o    (cnt),
    .bank_o   (bank),
    .write_o  (wr),
    .addr_o   (baddr),
    .wdata_o  (wdata),
    .mux_o    (mux),
    .wid_o    (wid)
  );

  xbus_pins #(.NB(NB), .AW(AW), .DW(DW)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_i (phase),
    .cnt_i   (cnt),
    .bank_i  (bank),
    .write_i (wr),
    .addr_i  (baddr),
    .wdata_i (wdata),
    .mux_i   (mux),
    .wid_i   (wid),
    .mem_ne  (mem_ne),
    .mem_nadv(mem_nadv),
    .mem_noe (mem_noe),
    .mem_nwe (mem_nwe),
    .mem_addr(mem_addr),
    .mem_dout(mem_dout),
    .mem_doe (mem_doe)
  );

  // R9: a disabled bank never opens a chip select
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (&mem_ne && mem_noe && mem_nwe && mem_nadv));

endmodule

// File: tb/xbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module xbus_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_en, cfg_mux;
  logic [7:0]  cfg_wid;
  logic [15:0] cfg_ast, cfg_aht;
  logic [31:0] cfg_dst;
  logic        req_valid, req_ready, req_write;
  logic [27:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  mem_ne;
  logic        mem_nadv, mem_noe, mem_nwe, mem_doe;
  logic [25:0] mem_addr;
  logic [31:0] mem_dout, mem_din;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign mem_din = {cyc[15:0] ^ 16'hA5C3, ~cyc[15:0]};

  xbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_mux(cfg_mux), .cfg_wid(cfg_wid),
    .cfg_ast(cfg_ast), .cfg_aht(cfg_aht), .cfg_dst(cfg_dst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mem_ne(mem_ne), .mem_nadv(mem_nadv), .mem_noe(mem_noe), .mem_nwe(mem_nwe),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic set_bank(input int b, input bit en, input bit mx, input logic [1:0] w,
                          input logic [3:0] ast, input logic [3:0] aht, input logic [7:0] dst);
    cfg_en[b]          = en;
    cfg_mux[b]         = mx;
    cfg_wid[2*b +: 2]  = w;
    cfg_ast[4*b +: 4]  = ast;
    cfg_aht[4*b +: 4]  = aht;
    cfg_dst[8*b +: 8]  = dst;
  endtask

  // Reference model: phase lengths and pin values from the requirements
  task automatic run_txn(input bit wr, input logic [27:0] a, input logic [31:0] wd, input int bp);
    int b, nA, nH, nD, shft, j;
    bit en, mx;
    logic [1:0]  w;
    logic [31:0] msk, exp_rd;
    logic [25:0] eaddr;
    logic [3:0]  ene;
    string ptag;
    b   = int'(a[27:26]);
    en  = cfg_en[b];
    mx  = cfg_mux[b];
    w   = cfg_wid[2*b +: 2];
    nA  = int'(cfg_ast[4*b +: 4]) + 1;
    nH  = mx ? ((cfg_aht[4*b +: 4] == 0) ? 2 : int'(cfg_aht[4*b +: 4]) + 1) : 0;
    nD  = (cfg_dst[8*b +: 8] == 0) ? 2 : int'(cfg_dst[8*b +: 8]) + 1;
    shft = (w == 2'd0) ? 0 : (w == 2'd1) ? 1 : 2;
    msk = (w == 2'd0) ? 32'hFF : (w == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    eaddr = a[25:0] >> shft;
    ene = 4'hF & ~(4'b0001 << b);
    exp_rd = '0;

    @(negedge clk);
    chk("R10", "ready before request", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    rsp_ready = (bp == 0);
    @(negedge clk);
    req_valid = 1'b0;
    if (!en) begin
      chk("R9", "strobes on disabled bank", {57'd0, mem_ne, mem_nadv, mem_noe, mem_nwe}, {57'd0, 7'h7F});
      chk("R9", "error response", {30'd0, rsp_valid, rsp_err, rsp_rdata}, {30'd0, 2'b11, 32'd0});
    end else begin
      for (int k = 0; k < nA + nH + nD; k++) begin
        if (k > 0) @(negedge clk);
        j = k - nA - nH;
        ptag = (k < nA) ? "R2" : (k < nA + nH) ? "R3" : "R4";
        chk("R1", {ptag, " chip select"}, {60'd0, mem_ne}, {60'd0, ene});
        chk("R3", {ptag, " address valid"}, {63'd0, mem_nadv}, {63'd0, !(mx && k < nA)});
        chk("R5", {ptag, " output enable"}, {63'd0, mem_noe}, {63'd0, !(!wr && j >= 0)});
        chk("R6", {ptag, " write enable"}, {63'd0, mem_nwe}, {63'd0, !(wr && j >= 0 && j < nD - 1)});
        chk("R3", {ptag, " data drive"}, {63'd0, mem_doe}, {63'd0, (mx && j < 0) || (wr && j >= 0)});
        chk("R7", {ptag, " memory address"}, {38'd0, mem_addr}, {38'd0, eaddr});
        chk("R10", {ptag, " busy handshake"}, {62'd0, req_ready, rsp_valid}, 64'd0);
        if (j < 0 && mx)
          chk("R3", "address on data lines", {32'd0, mem_dout}, {38'd0, eaddr});
        if (j >= 0 && wr)
          chk("R6", "write data", {32'd0, mem_dout}, {32'd0, wd & msk});
        if (j == nD - 1) exp_rd = mem_din & msk;
      end
      @(negedge clk);
      chk("R8", "idle clock strobes", {57'd0, mem_ne, mem_nadv, mem_noe, mem_nwe}, {57'd0, 7'h7F});
      chk("R8", "response raised", {62'd0, rsp_valid, rsp_err}, {62'd0, 2'b10});
      chk(wr ? "R6" : "R5", "response data", {32'd0, rsp_rdata}, {32'd0, wr ? 32'd0 : exp_rd});
    end
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      chk("R10", "held response", {30'd0, rsp_valid, req_ready, rsp_rdata}, {30'd0, 2'b10, wr ? 32'd0 : exp_rd});
      chk("R10", "strobes while held", {60'd0, mem_ne}, 64'hF);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10", "response consumed", {62'd0, rsp_valid, req_ready}, {62'd0, 2'b01});
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_en = '0; cfg_mux = '0; cfg_wid = '0; cfg_ast = '0; cfg_aht = '0; cfg_dst = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset chip selects", {60'd0, mem_ne}, 64'hF);
    chk("R8", "reset strobes", {61'd0, mem_nadv, mem_noe, mem_nwe}, 64'h7);
    chk("R10", "reset handshake", {62'd0, req_ready, rsp_valid}, {62'd0, 2'b10});
    rst_n = 1'b1;

    set_bank(0, 1, 0, 2'd1, 4'd0,  4'd0,  8'd1);
    set_bank(1, 1, 1, 2'd0, 4'd2,  4'd0,  8'd3);
    set_bank(2, 1, 1, 2'd2, 4'd15, 4'd15, 8'd255);
    set_bank(3, 0, 0, 2'd3, 4'd1,  4'd5,  8'd0);

    run_txn(1'b0, {2'd0, 26'h0123457}, 32'h0, 0);
    run_txn(1'b1, {2'd1, 26'h0000ABC}, 32'hDEAD_BEEF, 0);
    run_txn(1'b0, {2'd2, 26'h3FFFFFF}, 32'h0, 0);
    run_txn(1'b1, {2'd3, 26'h0000010}, 32'h1234_5678, 0);
    set_bank(3, 1, 0, 2'd3, 4'd1, 4'd5, 8'd0);
    run_txn(1'b1, {2'd3, 26'h2000014}, 32'h1234_5678, 3);
    run_txn(1'b0, {2'd1, 26'h0000055}, 32'h0, 2);
    run_txn(1'b1, {2'd0, 26'h0000F02}, 32'hCAFE_F00D, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule